// File: doc/BRIEF.md
# I2C Direction-Tracking Bus Repeater Controller

This block is the digital core of a repeater that joins two I2C segments: a master segment with a clock line and a data line, and a slave segment with its own data line and a forwarded clock. A fast system clock samples the lines. Each line passes through a synchronizer and a short glitch filter. Master clock lows are always copied onto the slave clock line.

The data line is not a symmetric buffer. The block follows each transaction: START, the address byte, the read/write flag, and every acknowledge slot. From this it knows which side owns SDA in the current bit slot, and it copies lows only in that direction. The owner changes on the master clock falling edge that ends a slot, so the new driver is enabled only while the forwarded clock is low.

Each open-drain pin is modelled as a sampled level plus a pull-low enable. Two active-low reset inputs each release both data lines at once and abandon the tracked transfer. An internal power-up timer keeps every pull-low off until it expires.

Top module: `i2c_dir_repeater`

## Requirements
- R1: `s_scl_pull` equals the inverse of the master clock level, delayed by exactly SYNC_STAGES+FILT_LEN+1 system clock edges, whatever state the tracker is in.
- R2: After a START, slots 0 to 7 carry the address and the read flag, sent MSB first. Slot 7 high means read. In these slots master lows are copied to the slave side. In slot 8 slave lows are copied to the master side.
- R3: If the read flag is 0, each later byte copies master to slave for slots 0 to 7 and slave to master for the acknowledge slot 8.
- R4: If the read flag is 1, each later byte copies slave to master for slots 0 to 7 and master to slave for slot 8. A low level in slot 8 means acknowledge.
- R5: A high level sampled in any acknowledge slot (a not-acknowledge) makes every later slot copy master to slave, until the next START or STOP.
- R6: A STOP (SDA rising while SCL is high) returns the block to idle, where only master lows are copied. A START, including a repeated START, restarts address decoding at slot 0.
- R7: Direction changes only after a falling master clock edge, one system cycle after the forwarded clock goes low. `m_sda_pull` and `s_sda_pull` are never high at the same time.
- R8: While either `rst1_n` or `rst2_n` is low, both SDA pull-lows are released at once, without waiting for a clock edge, even for a pulse shorter than one clock period. Afterwards the block is idle.
- R9: Reset release is synchronized. The data pull-lows stay released for at least RST_STAGES further clock edges after both resets are high.
- R10: For POR_CYCLES cycles after power-up, all three pull-lows stay released, whatever the inputs.
- R11: A clock change and a data change seen at the same time reach the slave side with the same latency.
- R12: A level that lasts fewer than FILT_LEN system cycles is not copied. A level that lasts FILT_LEN cycles is copied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst1_n | input | 1 | First active-low reset, asynchronous assert |
| rst2_n | input | 1 | Second active-low reset, asynchronous assert |
| m_scl_i | input | 1 | Sampled level of the master-side clock line |
| m_sda_i | input | 1 | Sampled level of the master-side data line |
| s_sda_i | input | 1 | Sampled level of the slave-side data line |
| s_scl_pull | output | 1 | Pull-low enable for the slave-side clock line |
| m_sda_pull | output | 1 | Pull-low enable for the master-side data line |
| s_sda_pull | output | 1 | Pull-low enable for the slave-side data line |

## Verification
The bench builds the block with its default parameters:
- two synchronizer stages and two reset stages;
- a three-sample filter;
- a 160-cycle power-up hold.

With these values the forwarding latency is a fixed six cycles. The bench measures that latency on the clock path and on the data path. It also sends pulses of two and three cycles to hit both sides of the filter threshold. The power-up hold is short enough to sample before and after it expires.

The bench drives a 16-cycle quarter bit period. This leaves room for the registered direction switch inside the clock low phase. It also allows a reset pulse narrower than one clock period to be placed between edges in the middle of a byte.

// File: rtl/rptr_pkg.sv
`timescale 1ns/1ps
package rptr_pkg;

  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned ACK_SLOT  = BYTE_BITS;
  localparam int unsigned RW_SLOT   = BYTE_BITS - 1;
  localparam int unsigned SLOT_W    = $clog2(ACK_SLOT + 1);

  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_HALT = 2'd3
  } phase_e;

  // slot index after the one that just ended
  function automatic slot_t next_slot(input slot_t cur);
    return (cur == slot_t'(ACK_SLOT)) ? slot_t'(0) : cur + slot_t'(1);
  endfunction

  // phase after the slot that just ended, given the sampled ack level
  function automatic phase_e next_phase(input phase_e ph, input slot_t cur, input logic nack);
    if (cur != slot_t'(ACK_SLOT)) return ph;
    if (nack || ph == PH_HALT)    return PH_HALT;
    return PH_DATA;
  endfunction

  // 1 when the slave-side device owns SDA in the given slot
  function automatic logic slave_owns(input phase_e ph, input slot_t slot, input logic rd);
    logic ack;
    ack = (slot == slot_t'(ACK_SLOT));
    case (ph)
      PH_ADDR: return ack;
      PH_DATA: return rd ? !ack : ack;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rptr_line_cond.sv
`timescale 1ns/1ps
module rptr_line_cond #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic filt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_out;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end
  assign sync_out = sync_q[SYNC_STAGES-1];

  generate
    if (FILT_LEN > 1) begin : g_window
      localparam int unsigned HL = FILT_LEN - 1;
      logic [HL-1:0]       hist_q;
      logic [FILT_LEN-1:0] window;
      logic                filt_q;

      assign window = {hist_q, sync_out};

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hist_q <= '1;
          filt_q <= 1'b1;
        end else begin
          if (HL > 1) hist_q <= window[HL-1:0];
          else        hist_q <= window[HL-1:0];
          if (&window)       filt_q <= 1'b1;
          else if (~|window) filt_q <= 1'b0;
        end
      end
      assign filt = filt_q;

      AST_FILT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(sync_out) == filt_q)); // R12
    end else begin : g_direct
      assign filt = sync_out;
    end
  endgenerate

endmodule

// File: rtl/rptr_rst_ctrl.sv
`timescale 1ns/1ps
module rptr_rst_ctrl #(
  parameter int unsigned RST_STAGES = 2,
  parameter int unsigned POR_CYCLES = 160
) (
  input  logic clk,
  input  logic rst1_n,
  input  logic rst2_n,
  output logic arst_n,
  output logic por_done,
  output logic core_rst_n
);

  localparam int unsigned CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0]         por_cnt  = '0;
  logic                  por_q    = 1'b0;
  logic [RST_STAGES-1:0] sync_q;
  logic                  core_q;

  assign arst_n = rst1_n & rst2_n;

  always_ff @(posedge clk) begin
    if (!por_q) begin
      por_cnt <= por_cnt + CW'(1);
      if (por_cnt == CW'(POR_CYCLES - 1)) por_q <= 1'b1;
    end
  end
  assign por_done = por_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
      core_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[RST_STAGES-2:0], 1'b1};
      core_q <= sync_q[RST_STAGES-1] & por_q;
    end
  end
  assign core_rst_n = core_q;

  AST_CORE_HELD: assert property (@(posedge clk) disable iff (!por_done)
    !arst_n |=> !core_rst_n); // R9

endmodule

// File: rtl/rptr_tracker.sv
`timescale 1ns/1ps
module rptr_tracker
  import rptr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_now,
  input  logic scl_prev,
  input  logic sda_now,
  input  logic sda_prev,
  output logic dir_s2m
);

  logic   start_evt, stop_evt, scl_rise, scl_fall, slot_end;
  phase_e phase_q, phase_nx;
  slot_t  slot_q, slot_nx;
  logic   rd_q, ack_q, seen_q, dir_q;

  assign start_evt = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_evt  = scl_now & scl_prev & ~sda_prev & sda_now;
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign slot_end  = scl_fall & seen_q & (phase_q != PH_IDLE);

  assign slot_nx  = next_slot(slot_q);
  assign phase_nx = next_phase(phase_q, slot_q, ack_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      slot_q  <= '0;
      rd_q    <= 1'b0;
      ack_q   <= 1'b0;
      seen_q  <= 1'b0;
      dir_q   <= 1'b0;
    end else if (start_evt) begin
      phase_q <= PH_ADDR;
      slot_q  <= '0;
      seen_q  <= 1'b0;
      dir_q   <= 1'b0;
    end else if (stop_evt) begin
      phase_q <= PH_IDLE;
      slot_q  <= '0;
      seen_q  <= 1'b0;
      dir_q   <= 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        seen_q <= 1'b1;
        if (phase_q == PH_ADDR && slot_q == slot_t'(RW_SLOT)) rd_q <= sda_now;
        if (slot_q == slot_t'(ACK_SLOT)) ack_q <= sda_now;
      end
      if (slot_end) begin
        seen_q  <= 1'b0;
        slot_q  <= slot_nx;
        phase_q <= phase_nx;
        dir_q   <= slave_owns(phase_nx, slot_nx, rd_q);
      end
    end
  end
  assign dir_s2m = dir_q;

  AST_DIR_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dir_q) && !$past(start_evt) && !$past(stop_evt)) |-> !$past(scl_now)); // R7
  AST_IDLE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE || phase_q == PH_HALT) |-> !dir_q); // R6
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= slot_t'(ACK_SLOT)); // R2

endmodule

// File: rtl/i2c_dir_repeater.sv
`timescale 1ns/1ps
module i2c_dir_repeater #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3,
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned POR_CYCLES  = 160
) (
  input  logic clk,
  input  logic rst1_n,
  input  logic rst2_n,
  input  logic m_scl_i,
  input  logic m_sda_i,
  input  logic s_sda_i,
  output logic s_scl_pull,
  output logic m_sda_pull,
  output logic s_sda_pull
);

  localparam int unsigned LINES    = 3;
  localparam int unsigned IDX_MSCL = 0;
  localparam int unsigned IDX_MSDA = 1;
  localparam int unsigned IDX_SSDA = 2;

  logic             ext_arst_n, por_done, core_rst_n;
  logic [LINES-1:0] raw_lines, clean_lines;
  logic             mscl_d, msda_d;
  logic             dir_s2m;
  logic             s_scl_q, m_sda_q, s_sda_q;

  rptr_rst_ctrl #(.RST_STAGES(RST_STAGES), .POR_CYCLES(POR_CYCLES)) u_rst (
    .clk(clk), .rst1_n(rst1_n), .rst2_n(rst2_n),
    .arst_n(ext_arst_n), .por_done(por_done), .core_rst_n(core_rst_n)
  );

  assign raw_lines = {s_sda_i, m_sda_i, m_scl_i};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_cond
      rptr_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
        .clk(clk), .rst_n(por_done), .din(raw_lines[g]), .filt(clean_lines[g])
      );
    end
  endgenerate

  // previous filtered levels; kept out of the external reset so that
  // reset release never looks like a bus edge
  always_ff @(posedge clk) begin
    if (!por_done) begin
      mscl_d <= 1'b1;
      msda_d <= 1'b1;
    end else begin
      mscl_d <= clean_lines[IDX_MSCL];
      msda_d <= clean_lines[IDX_MSDA];
    end
  end

  rptr_tracker u_trk (
    .clk(clk), .rst_n(core_rst_n),
    .scl_now(clean_lines[IDX_MSCL]), .scl_prev(mscl_d),
    .sda_now(clean_lines[IDX_MSDA]), .sda_prev(msda_d),
    .dir_s2m(dir_s2m)
  );

  always_ff @(posedge clk) begin
    if (!por_done) s_scl_q <= 1'b0;
    else           s_scl_q <= !clean_lines[IDX_MSCL];
  end

  always_ff @(posedge clk or negedge ext_arst_n) begin
    if (!ext_arst_n) begin
      m_sda_q <= 1'b0;
      s_sda_q <= 1'b0;
    end else if (!core_rst_n) begin
      m_sda_q <= 1'b0;
      s_sda_q <= 1'b0;
    end else begin
      s_sda_q <= !dir_s2m && !clean_lines[IDX_MSDA];
      m_sda_q <=  dir_s2m && !clean_lines[IDX_SSDA];
    end
  end

  assign s_scl_pull = s_scl_q;
  assign m_sda_pull = m_sda_q;
  assign s_sda_pull = s_sda_q;

  AST_SDA_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(m_sda_pull && s_sda_pull)); // R7
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!por_done)
    !ext_arst_n |-> (!m_sda_pull && !s_sda_pull)); // R8
  AST_POR_QUIET: assert property (@(posedge clk) disable iff (!ext_arst_n)
    !por_done |-> (!s_scl_pull && !m_sda_pull && !s_sda_pull)); // R10

endmodule

// File: tb/sim_i2c_dir_repeater.sv
`timescale 1ns/1ps
module sim_i2c_dir_repeater;

  localparam int SYNC = 2;
  localparam int FILT = 3;
  localparam int RSTS = 2;
  localparam int POR  = 160;
  localparam int LAT  = SYNC + FILT + 1;
  localparam int Q    = 16;

  logic clk = 1'b0;
  logic rst1_n = 1'b0, rst2_n = 1'b1;
  logic m_scl = 1'b1, m_drv = 1'b1, s_drv = 1'b1;
  logic s_scl_pull, m_sda_pull, s_sda_pull;
  logic m_sda_line, s_sda_line;
  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  assign m_sda_line = m_drv & ~m_sda_pull;
  assign s_sda_line = s_drv & ~s_sda_pull;

  i2c_dir_repeater #(.SYNC_STAGES(SYNC), .FILT_LEN(FILT), .RST_STAGES(RSTS), .POR_CYCLES(POR)) u0 (
    .clk(clk), .rst1_n(rst1_n), .rst2_n(rst2_n),
    .m_scl_i(m_scl), .m_sda_i(m_sda_line), .s_sda_i(s_sda_line),
    .s_scl_pull(s_scl_pull), .m_sda_pull(m_sda_pull), .s_sda_pull(s_sda_pull)
  );

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit slot; entered and left with SCL low
  task automatic slot(input bit mb, input bit sb, input bit slave_turn, input string req);
    m_drv = mb; s_drv = sb;
    wait_n(Q);
    chk("R1", "scl low forwarded", int'(s_scl_pull), 1);
    m_scl = 1'b1;
    wait_n(Q);
    if (slave_turn) begin
      chk(req, "s2m m_sda_pull", int'(m_sda_pull), int'(!sb));
      chk(req, "s2m s_sda_pull", int'(s_sda_pull), 0);
    end else begin
      chk(req, "m2s s_sda_pull", int'(s_sda_pull), int'(!mb));
      chk(req, "m2s m_sda_pull", int'(m_sda_pull), 0);
    end
    wait_n(Q);
    m_scl = 1'b0;
    wait_n(Q);
  endtask

  task automatic byte_xfer(input logic [7:0] d, input bit from_slave, input bit ackv, input string req);
    for (int i = 7; i >= 0; i--) begin
      if (from_slave) slot(1'b1, d[i], 1'b1, req);
      else            slot(d[i], 1'b1, 1'b0, req);
    end
    if (from_slave) slot(ackv, 1'b1, 1'b0, req);
    else            slot(1'b1, ackv, 1'b1, req);
  endtask

  task automatic start_cond();
    m_drv = 1'b0; s_drv = 1'b1;
    wait_n(2*Q);
    m_scl = 1'b0;
    wait_n(Q);
  endtask

  task automatic rstart_cond();
    m_drv = 1'b1; s_drv = 1'b1;
    wait_n(Q);
    m_scl = 1'b1;
    wait_n(Q);
    m_drv = 1'b0;
    wait_n(Q);
    m_scl = 1'b0;
    wait_n(Q);
  endtask

  task automatic stop_cond(input string req);
    m_drv = 1'b0; s_drv = 1'b1;
    wait_n(Q);
    m_scl = 1'b1;
    wait_n(Q);
    chk(req, "master low before STOP forwarded", int'(s_sda_pull), 1);
    m_drv = 1'b1;
    wait_n(2*Q);
    chk(req, "released after STOP", int'(s_sda_pull), 0);
  endtask

  task automatic t_por();
    m_scl = 1'b0; m_drv = 1'b0;
    wait_n(20);
    rst1_n = 1'b1;
    wait_n(80);
    chk("R10", "scl pull during POR", int'(s_scl_pull), 0);
    chk("R10", "sda pull during POR", int'(s_sda_pull), 0);
    wait_n(45);
    chk("R10", "late POR all pulls", int'(s_scl_pull | s_sda_pull | m_sda_pull), 0);
    wait_n(50);
    chk("R1", "scl forwarded after POR", int'(s_scl_pull), 1);
    chk("R10", "sda forwarded after POR", int'(s_sda_pull), 1);
    m_drv = 1'b1; wait_n(10);
    m_scl = 1'b1; wait_n(20);
  endtask

  task automatic t_latency();
    int n_c, n_d;
    @(negedge clk); m_scl = 1'b0;
    n_c = 0;
    do begin @(negedge clk); n_c++; end while (!s_scl_pull && n_c < 20);
    chk("R1", "clock forwarding latency", n_c, LAT);
    wait_n(10);
    m_drv = 1'b0;
    n_d = 0;
    do begin @(negedge clk); n_d++; end while (!s_sda_pull && n_d < 20);
    chk("R11", "data latency equals clock latency", n_d, n_c);
    m_drv = 1'b1; wait_n(10);
    m_scl = 1'b1; wait_n(20);
  endtask

  task automatic t_glitch();
    int seen;
    m_scl = 1'b0; wait_n(20);
    m_drv = 1'b0; wait_n(FILT-1); m_drv = 1'b1;
    seen = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); seen |= int'(s_sda_pull); end
    chk("R12", "short pulse suppressed", seen, 0);
    m_drv = 1'b0; wait_n(FILT); m_drv = 1'b1;
    seen = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); seen |= int'(s_sda_pull); end
    chk("R12", "threshold pulse forwarded", seen, 1);
    m_scl = 1'b1; wait_n(20);
  endtask

  task automatic t_write_rstart();
    start_cond();
    byte_xfer(8'hA4, 1'b0, 1'b0, "R2");
    byte_xfer(8'h3C, 1'b0, 1'b0, "R3");
    byte_xfer(8'hC3, 1'b0, 1'b0, "R3");
    rstart_cond();
    // repeated START: read address, slave declines it
    byte_xfer(8'hA5, 1'b0, 1'b1, "R6");
    stop_cond("R5");
    // idle: slave low must not reach master side
    m_scl = 1'b0; wait_n(Q);
    s_drv = 1'b0; wait_n(2*Q);
    chk("R6", "idle blocks slave-to-master", int'(m_sda_pull), 0);
    s_drv = 1'b1; wait_n(Q);
    m_scl = 1'b1; wait_n(2*Q);
  endtask

  task automatic t_read_nack();
    start_cond();
    byte_xfer(8'hA5, 1'b0, 1'b0, "R2");
    byte_xfer(8'h5A, 1'b1, 1'b0, "R4");
    byte_xfer(8'h96, 1'b1, 1'b1, "R4");
    stop_cond("R5");
  endtask

  task automatic t_reset_write();
    start_cond();
    byte_xfer(8'hA4, 1'b0, 1'b0, "R2");
    slot(1'b1, 1'b1, 1'b0, "R3");
    slot(1'b0, 1'b1, 1'b0, "R3");
    slot(1'b1, 1'b1, 1'b0, "R3");
    m_drv = 1'b0; wait_n(Q);
    m_scl = 1'b1; wait_n(Q);
    chk("R3", "forwarding before reset", int'(s_sda_pull), 1);
    #1 rst2_n = 1'b0;
    #1 chk("R8", "s_sda_pull released at once", int'(s_sda_pull), 0);
    chk("R8", "m_sda_pull released at once", int'(m_sda_pull), 0);
    #0.5 rst2_n = 1'b1;
    wait_n(RSTS);
    chk("R9", "held after release", int'(s_sda_pull), 0);
    wait_n(Q);
    m_scl = 1'b0; wait_n(Q);
    for (int i = 0; i < 4; i++) slot(1'b1, 1'b1, 1'b0, "R8");
    // would have been the slave ack slot; transfer was abandoned
    slot(1'b0, 1'b0, 1'b0, "R8");
    stop_cond("R8");
    start_cond();
    byte_xfer(8'hA4, 1'b0, 1'b0, "R6");
    stop_cond("R6");
  endtask

  task automatic t_reset_read();
    start_cond();
    byte_xfer(8'hA5, 1'b0, 1'b0, "R2");
    slot(1'b1, 1'b1, 1'b1, "R4");
    slot(1'b1, 1'b0, 1'b1, "R4");
    m_drv = 1'b1; s_drv = 1'b0; wait_n(Q);
    m_scl = 1'b1; wait_n(Q);
    chk("R4", "slave low forwarded", int'(m_sda_pull), 1);
    #1 rst1_n = 1'b0;
    #1 chk("R8", "m_sda_pull released at once", int'(m_sda_pull), 0);
    #1 rst1_n = 1'b1;
    wait_n(Q);
    m_scl = 1'b0; wait_n(Q);
    slot(1'b1, 1'b0, 1'b0, "R8");
    stop_cond("R8");
  endtask

  initial begin
    t_por();
    t_latency();
    t_glitch();
    t_write_rstart();
    t_read_nack();
    t_reset_write();
    t_reset_read();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule